// File: doc/BRIEF.md
# DRAM Bank Decode and Address Multiplexer

This block turns one processor-side byte access into the strobe sequence that a bank of 16-bit-wide DRAM devices expects. The upper address bits pick the device row (bank) that receives a RAS strobe. The in-device word address is split into a row half and a column half, and both halves are sent over one shared set of multiplexed address pins. Address bit 0, or a word-size flag, picks the byte lanes through the two CAS strobes. The write-enable and output-enable strobes are shared by every device and are driven around the CAS phase.

A configuration input selects the array geometry:
- **Narrow geometry** (1M-deep devices): ten address pins and up to four RAS lines.
- **Wide geometry** (4M-deep devices): eleven address pins and two RAS lines.

The request fields are captured when a request is accepted. Acceptance happens only while the block is idle. A one-cycle done pulse marks the first idle cycle after the strobes are released. Each phase of the access lasts for a number of clock cycles set by a parameter.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: With `geom_wide`=0, the pins `ma[9:0]` carry addr[20:11] during the row phases and addr[10:1] during the column phases. `ma[10]` stays 0.
- R2: With `geom_wide`=1, the pins `ma[10:0]` carry addr[22:12] during the row phases and addr[11:1] during the column phases.
- R3: With `geom_wide`=0, the value of addr[22:21] selects the active-low line: 0 gives `ras_n[0]`, 1 gives `ras_n[1]`, 2 gives `ras_n[2]`, 3 gives `ras_n[3]`.
- R4: With `geom_wide`=1, addr[23] selects the line: 0 gives `ras_n[0]` and 1 gives `ras_n[1]`. `ras_n[3:2]` stay high.
- R5: For a byte access (`word`=0), addr[0]=0 drives `cas_n[0]` low (low byte). addr[0]=1 drives `cas_n[1]` low (high byte).
- R6: For a word access (`word`=1), both CAS lines go low together, whatever the value of addr[0].
- R7: For a write, `we_n` is low from the start of column setup to the end of the CAS phase, and `oe_n` stays high. For a read, `oe_n` is low only during the CAS phase, and `we_n` stays high.
- R8: An accepted access runs through these phases in order:
  1. Row setup: T_ROW cycles with the row on the pins and all strobes high.
  2. RAS: T_RAS cycles with RAS low.
  3. Column setup: T_COL cycles with the column on the pins and RAS still low.
  4. CAS: T_CAS cycles with CAS low.
  5. Release: T_REL cycles with every strobe high.
- R9: All strobes are active low. When idle, every strobe is high and `ma` is 0.
- R10: `done` is high for exactly one cycle, the first idle cycle after release. A request presented in that cycle is accepted.
- R11: A request is accepted only when idle. While an access is in progress, `req` and changes on `addr`, `wr`, `word` and `geom_wide` have no effect on the outputs.
- R12: After a synchronous active-low reset, the outputs are in the idle state and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| geom_wide | input | 1 | 0: 1M-deep devices, 1: 4M-deep devices; captured at acceptance |
| req | input | 1 | Access request, taken when idle |
| wr | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit access on both byte lanes |
| addr | input | 24 | Processor byte address |
| ma | output | 11 | Multiplexed row/column address |
| ras_n | output | 4 | Row strobes, active low |
| cas_n | output | 2 | Byte-lane column strobes, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| done | output | 1 | One-cycle pulse in the first idle cycle after an access |

## Verification
The assertions assume that the captured request, and not the live inputs, decides the bank and lane pattern. They therefore hold even when `req`, `addr` and `geom_wide` change freely during an access. The stable-address check assumes that the column never changes while CAS is low, which the sequencer guarantees only because the fields are latched. The stimulus keeps `req` high with altered address, width, direction and geometry for the whole of each busy period, so every cycle of every access also tests that these inputs are ignored. It covers both geometries, every bank code, both lane settings and back-to-back requests issued in the done cycle.

// File: rtl/dram_mux_pkg.sv
// Shared types and widths for the DRAM strobe controller.
// Assumes a 24-bit byte address and 16-bit devices with two byte lanes.
package dram_mux_pkg;
    localparam int ADDR_W = 24;
    localparam int MA_W   = 11;
    localparam int NRAS   = 4;
    localparam int NLANE  = 2;

    // Access phases, in the order they are visited.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ROW  = 3'd1,
        PH_RAS  = 3'd2,
        PH_COL  = 3'd3,
        PH_CAS  = 3'd4,
        PH_REL  = 3'd5
    } phase_e;

    // Request fields captured at acceptance.
    typedef struct packed {
        logic              wide;
        logic              wr;
        logic              word;
        logic [ADDR_W-1:0] addr;
    } acc_req_t;
endpackage

// File: rtl/dram_addr_split.sv
// Splits a captured request into row, column, bank select and lane select.
// Assumes the request is held stable for the whole access (latched by the top).
module dram_addr_split
    import dram_mux_pkg::*;
(
    input  acc_req_t         req_i,
    output logic [MA_W-1:0]  row_o,
    output logic [MA_W-1:0]  col_o,
    output logic [NRAS-1:0]  bank_o,
    output logic [NLANE-1:0] lane_o
);
    localparam int BANK_W = $clog2(NRAS);

    logic [BANK_W-1:0] bank_code;

    // Geometry-dependent row/column/bank extraction.
    always_comb begin
        if (req_i.wide) begin
            row_o     = req_i.addr[22:12];
            col_o     = req_i.addr[11:1];
            bank_code = {1'b0, req_i.addr[23]};
        end else begin
            row_o     = {1'b0, req_i.addr[20:11]};
            col_o     = {1'b0, req_i.addr[10:1]};
            bank_code = req_i.addr[22:21];
        end
    end

    // One-hot bank decode, one comparator per RAS line.
    for (genvar g = 0; g < NRAS; g++) begin : g_bank
        assign bank_o[g] = (bank_code == BANK_W'(g));
    end

    // Byte-lane select: both lanes for a word access, else by address bit 0.
    always_comb begin
        if (req_i.word) lane_o = '1;
        else            lane_o = req_i.addr[0] ? 2'b10 : 2'b01;
    end
endmodule

// File: rtl/dram_phase_seq.sv
// Phase sequencer: walks row setup, RAS, column setup, CAS and release,
// each for a parameter number of cycles (each must be at least 1).
// Accepts a start only in idle and pulses done on return to idle.
module dram_phase_seq
    import dram_mux_pkg::*;
#(
    parameter int T_ROW = 1,
    parameter int T_RAS = 2,
    parameter int T_COL = 1,
    parameter int T_CAS = 2,
    parameter int T_REL = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    output logic   accept_o,
    output phase_e phase_o,
    output logic   done_o
);
    localparam int MAX_A = (T_ROW > T_RAS) ? T_ROW : T_RAS;
    localparam int MAX_B = (T_COL > T_CAS) ? T_COL : T_CAS;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > T_REL) ? MAX_C : T_REL;
    localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;

    phase_e             phase_q, phase_nx;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   load_val;
    logic               last;

    assign accept_o = start_i && (phase_q == PH_IDLE);
    assign last     = (cnt_q == '0);
    assign phase_o  = phase_q;

    // Next phase and its cycle count when the current phase ends.
    always_comb begin
        phase_nx = phase_q;
        load_val = '0;
        unique case (phase_q)
            PH_IDLE: begin phase_nx = PH_ROW;  load_val = CNT_W'(T_ROW - 1); end
            PH_ROW:  begin phase_nx = PH_RAS;  load_val = CNT_W'(T_RAS - 1); end
            PH_RAS:  begin phase_nx = PH_COL;  load_val = CNT_W'(T_COL - 1); end
            PH_COL:  begin phase_nx = PH_CAS;  load_val = CNT_W'(T_CAS - 1); end
            PH_CAS:  begin phase_nx = PH_REL;  load_val = CNT_W'(T_REL - 1); end
            PH_REL:  begin phase_nx = PH_IDLE; load_val = '0;                end
            default: begin phase_nx = PH_IDLE; load_val = '0;                end
        endcase
    end

    // Phase register and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (start_i) begin
                phase_q <= phase_nx;
                cnt_q   <= load_val;
            end
        end else if (last) begin
            phase_q <= phase_nx;
            cnt_q   <= load_val;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Done pulse for the first idle cycle after release.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (phase_q == PH_REL) && last;
    end
endmodule

// File: rtl/dram_strobe_drive.sv
// Maps the current phase and decoded fields onto the DRAM pins.
// Pure decode of registered state; strobes are active low.
module dram_strobe_drive
    import dram_mux_pkg::*;
(
    input  phase_e           phase_i,
    input  logic             wr_i,
    input  logic [MA_W-1:0]  row_i,
    input  logic [MA_W-1:0]  col_i,
    input  logic [NRAS-1:0]  bank_i,
    input  logic [NLANE-1:0] lane_i,
    output logic [MA_W-1:0]  ma_o,
    output logic [NRAS-1:0]  ras_n_o,
    output logic [NLANE-1:0] cas_n_o,
    output logic             we_n_o,
    output logic             oe_n_o
);
    // Pin values per phase.
    always_comb begin
        ma_o    = '0;
        ras_n_o = '1;
        cas_n_o = '1;
        we_n_o  = 1'b1;
        oe_n_o  = 1'b1;
        unique case (phase_i)
            PH_ROW: ma_o = row_i;
            PH_RAS: begin
                ma_o    = row_i;
                ras_n_o = ~bank_i;
            end
            PH_COL: begin
                ma_o    = col_i;
                ras_n_o = ~bank_i;
                we_n_o  = ~wr_i;
            end
            PH_CAS: begin
                ma_o    = col_i;
                ras_n_o = ~bank_i;
                cas_n_o = ~lane_i;
                we_n_o  = ~wr_i;
                oe_n_o  = wr_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_strobe_ctrl.sv
// Top: captures a request while idle and drives one DRAM access through
// the phase sequencer. Inputs other than clk/rst_n are sampled only at acceptance.
module dram_strobe_ctrl
    import dram_mux_pkg::*;
#(
    parameter int T_ROW = 1,
    parameter int T_RAS = 2,
    parameter int T_COL = 1,
    parameter int T_CAS = 2,
    parameter int T_REL = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                geom_wide,
    input  logic                req,
    input  logic                wr,
    input  logic                word,
    input  logic [ADDR_W-1:0]   addr,
    output logic [MA_W-1:0]     ma,
    output logic [NRAS-1:0]     ras_n,
    output logic [NLANE-1:0]    cas_n,
    output logic                we_n,
    output logic                oe_n,
    output logic                done
);
    acc_req_t          acc_q;
    logic              accept;
    phase_e            phase;
    logic [MA_W-1:0]   row, col;
    logic [NRAS-1:0]   bank;
    logic [NLANE-1:0]  lane;
    logic              cfg_wide_q;

    assign cfg_wide_q = acc_q.wide;

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else if (accept) acc_q <= '{wide: geom_wide, wr: wr, word: word, addr: addr};
    end

    dram_phase_seq #(
        .T_ROW(T_ROW), .T_RAS(T_RAS), .T_COL(T_COL), .T_CAS(T_CAS), .T_REL(T_REL)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (req),
        .accept_o(accept),
        .phase_o (phase),
        .done_o  (done)
    );

    dram_addr_split u_split (
        .req_i (acc_q),
        .row_o (row),
        .col_o (col),
        .bank_o(bank),
        .lane_o(lane)
    );

    dram_strobe_drive u_drv (
        .phase_i(phase),
        .wr_i   (acc_q.wr),
        .row_i  (row),
        .col_i  (col),
        .bank_i (bank),
        .lane_i (lane),
        .ma_o   (ma),
        .ras_n_o(ras_n),
        .cas_n_o(cas_n),
        .we_n_o (we_n),
        .oe_n_o (oe_n)
    );
endmodule

// File: rtl/dram_strobe_ctrl_chk.sv
// Property checker for dram_strobe_ctrl, attached by bind below.
module dram_strobe_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [10:0] ma,
    input logic [3:0]  ras_n,
    input logic [1:0]  cas_n,
    input logic        we_n,
    input logic        oe_n,
    input logic        done,
    input logic        cfg_wide_q
);
    AST_RAS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ras_n) <= 1); // R3
    AST_WIDE_UPPER_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wide_q |-> (ras_n[3:2] == 2'b11)); // R4
    AST_NARROW_TOP_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wide_q |-> (ma[10] == 1'b0)); // R1
    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n != 2'b11) |-> (ras_n != 4'hF)); // R8
    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n)); // R7
    AST_OE_INSIDE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (cas_n != 2'b11)); // R7
    AST_COLUMN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cas_n != 2'b11) && $past(cas_n != 2'b11)) |-> $stable(ma)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ras_n == 4'hF && cas_n == 2'b11 && we_n && oe_n)); // R10
endmodule

bind dram_strobe_ctrl dram_strobe_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ma        (ma),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .done      (done),
    .cfg_wide_q(cfg_wide_q)
);

// File: tb/sim_dram_strobe_ctrl.sv
// Bench: behavioural model pushes the expected pin vectors of each accepted
// access into a queue; every cycle the head (or the idle vector) is compared.
module sim_dram_strobe_ctrl;
    localparam int P_ROW = 1, P_RAS = 2, P_COL = 1, P_CAS = 2, P_REL = 1;

    typedef struct {
        logic [10:0] ma;
        logic [3:0]  ras;
        logic [1:0]  cas;
        logic        we, oe, dn, idle, wide, word;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        geom_wide = 1'b0, req = 1'b0, wr = 1'b0, word = 1'b0;
    logic [23:0] addr = '0;
    logic [10:0] ma;
    logic [3:0]  ras_n;
    logic [1:0]  cas_n;
    logic        we_n, oe_n, done;

    exp_t q[$];
    bit   cur_idle = 1'b1;
    int   n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    dram_strobe_ctrl #(.T_ROW(P_ROW), .T_RAS(P_RAS), .T_COL(P_COL),
                       .T_CAS(P_CAS), .T_REL(P_REL)) u0 (
        .clk(clk), .rst_n(rst_n), .geom_wide(geom_wide), .req(req), .wr(wr),
        .word(word), .addr(addr), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .done(done));

    function automatic exp_t idle_vec();
        exp_t e;
        e.ma = '0; e.ras = 4'hF; e.cas = 2'b11; e.we = 1; e.oe = 1;
        e.dn = 0; e.idle = 1; e.wide = 0; e.word = 0;
        return e;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Model: expected vectors for one access.
    task automatic push_access(bit wd, bit w, bit wordsz, logic [23:0] a);
        int row, col, bank;
        logic [3:0] rsel;
        logic [1:0] lane;
        exp_t e;
        if (wd) begin
            row = (a >> 12) & 'h7FF; col = (a >> 1) & 'h7FF; bank = (a >> 23) & 1;
        end else begin
            row = (a >> 11) & 'h3FF; col = (a >> 1) & 'h3FF; bank = (a >> 21) & 3;
        end
        rsel = 4'hF & ~(4'b0001 << bank);
        lane = wordsz ? 2'b00 : (a[0] ? 2'b01 : 2'b10);
        e = idle_vec(); e.idle = 0; e.wide = wd; e.word = wordsz;
        e.ma = 11'(row);
        for (int i = 0; i < P_ROW; i++) q.push_back(e);
        e.ras = rsel;
        for (int i = 0; i < P_RAS; i++) q.push_back(e);
        e.ma = 11'(col); e.we = ~w;
        for (int i = 0; i < P_COL; i++) q.push_back(e);
        e.cas = lane; e.oe = w;
        for (int i = 0; i < P_CAS; i++) q.push_back(e);
        e = idle_vec(); e.idle = 0;
        for (int i = 0; i < P_REL; i++) q.push_back(e);
        e = idle_vec(); e.dn = 1;
        q.push_back(e);
    endtask

    // Compare the pins against the model after the last edge.
    task automatic tick_check();
        exp_t e;
        @(negedge clk);
        if (!rst_n) begin
            e = idle_vec();
            chk("R12 reset ras_n", ras_n, e.ras);
            chk("R12 reset cas_n", cas_n, e.cas);
            chk("R12 reset done", done, 0);
            q.delete(); cur_idle = 1;
            return;
        end
        e = (q.size() > 0) ? q.pop_front() : idle_vec();
        cur_idle = e.idle;
        chk(e.wide ? "R2 R8 ma" : "R1 R8 ma", ma, e.ma);
        chk(e.wide ? "R4 R8 ras_n" : "R3 R8 ras_n", ras_n, e.ras);
        chk(e.word ? "R6 cas_n" : "R5 cas_n", cas_n, e.cas);
        chk("R7 we_n", we_n, e.we);
        chk("R7 oe_n", oe_n, e.oe);
        chk("R10 done", done, e.dn);
        if (e.idle) chk("R9 R11 idle pins", {ma, ras_n, cas_n, we_n, oe_n}, {11'd0, 4'hF, 2'b11, 2'b11});
    endtask

    task automatic drive(bit r, bit wd, bit w, bit wordsz, logic [23:0] a);
        req = r; geom_wide = wd; wr = w; word = wordsz; addr = a;
        if (rst_n && cur_idle && r) push_access(wd, w, wordsz, a);
    endtask

    // One access; while busy, keep req high with altered fields (R11).
    task automatic access(bit wd, bit w, bit wordsz, logic [23:0] a);
        drive(1, wd, w, wordsz, a);
        forever begin
            tick_check();
            if (cur_idle) break;
            drive(1, ~wd, ~w, ~wordsz, a ^ 24'hA5C3E1);
        end
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 0, 0, 24'h0);
            tick_check();
        end
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick_check();
        rst_n = 1'b1;
        idle_cycles(2);
        // narrow geometry: every bank code, both lanes, reads and writes
        access(0, 0, 0, 24'h000000);
        access(0, 1, 0, 24'h2ABCDF);
        access(0, 0, 0, 24'h4F00F1);
        access(0, 1, 1, 24'h7FFFFF);
        access(0, 0, 1, 24'h355554);
        idle_cycles(3);
        // wide geometry: both banks, lanes and word
        access(1, 1, 0, 24'h000002);
        access(1, 0, 0, 24'h800001);
        access(1, 1, 1, 24'hFFFFFF);
        access(1, 0, 1, 24'h5A5A5B);
        idle_cycles(2);
        access(0, 1, 0, 24'hC12345);
        access(1, 0, 0, 24'h7654FE);
        idle_cycles(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule